// File: doc/BRIEF.md
# Two-Channel DMA Channel Controller

This block is a register-programmed DMA engine with two independent channels that share one word-oriented memory port. For each channel, software writes a mode word, a start address and a byte count over a 32-bit register bus, then writes 1 to the channel's run register. The channel copies words from its own peripheral FIFO port onto the memory port. It advances a live address and decrements a live remaining-byte count with every accepted beat.

When the remaining count reaches zero, the channel drops its run bit by itself and sets its completion flag in a shared status register. Each flag is gated by a matching bit of an interrupt-mask register, and the gated flags are ORed onto a single interrupt output. Software clears a flag by writing 1 to it at the clear address. Writing 0 to a run register stops that channel at once, with no completion flag.

Top module: `dual_dma_ctrl`

## Requirements
- R1: Register map (byte addresses on `regAddr`; channel 1 registers sit 0x04 above the channel 0 ones):
  - 0x00 mode word.
  - 0x10 start address.
  - 0x18 byte count.
  - 0x20 live address (read-only).
  - 0x28 live remaining count (read-only).
  - 0x30 run register.
  - 0x40 interrupt mask.
  - 0x44 status (read-only).
  - 0x48 status clear.
  
  The mode word keeps only bit 12 (transmit buffering), bit 8 (receive-end handling) and bits 5:4 (wait count); all other mode bits read 0. The byte count is 26 bits wide. In the mask, status and clear registers, bit 0 is channel 0 and bit 1 is channel 1.
- R2: Writing a value with bit 0 set to a run register loads the live address and the remaining count from the start registers. The run register then reads 1 until the transfer ends.
- R3: Each accepted memory beat moves min(4, remaining) bytes. The address rises by that amount and the remaining count falls by it. `memByteEn` has that many low bits set (0x1, 0x3, 0x7 or 0xF), and `memAddr` is the live address before the beat.
- R4: When the remaining count is zero, the run register reads 0, the live address equals start address plus byte count, and the channel's status bit is set.
- R5: Writing a value with bit 0 clear to a run register stops the channel in the next cycle. No status bit is set, no further beats are issued, and the live address and count hold their values.
- R6: Writing 1s to the status clear register clears the matching status bits. Writes to the status address itself have no effect. A completion in the same cycle as a clear leaves the bit set.
- R7: `irq` is high exactly when some status bit and the same mask bit are both 1.
- R8: After each accepted beat, a channel waits as many idle cycles as its wait field (bits 5:4) before it requests the memory port again.
- R9: When both channels can request in the same cycle, channel 0 is served; `memChan` gives the channel of the current request.
- R10: A channel requests only while its `fifoValid` bit is high. An accepted beat (`memReq` and `memGnt`) pulses that channel's `fifoPop` bit, and `memWdata` carries that channel's `fifoData` word.
- R11: Starting with a byte count of 0 issues no beat. The run register reads 0 and the status bit is set within two cycles.
- R12: After reset, every register reads 0, and `irq` and `memReq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte address (read and write) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr`, combinational |
| fifoValid | input | 2 | Per-channel peripheral FIFO has a word |
| fifoData | input | 64 | Per-channel FIFO words, channel c in bits 32c+31:32c |
| fifoPop | output | 2 | Per-channel FIFO pop on an accepted beat |
| memReq | output | 1 | Memory beat request |
| memGnt | input | 1 | Memory accepts the requested beat this cycle |
| memChan | output | 1 | Channel owning the current request |
| memAddr | output | 32 | Beat byte address |
| memByteEn | output | 4 | Beat byte enables |
| memWdata | output | 32 | Beat write data |
| irq | output | 1 | Shared masked completion interrupt |

## Verification
Random transfers run with random start addresses, byte counts from 0 to 50 (many not multiples of four), random wait fields, and randomly throttled FIFO-valid and grant inputs. This shows whether the beat size, address stepping and end-of-transfer arithmetic hold whatever the stall pattern. Directed runs separate the remaining concerns:
- A run with grant and valid held high shows whether the wait gap is exact rather than merely long enough.
- Two channels started together with both FIFOs ready show priority against any interleaving.
- A stopped channel with ready inputs shows that a halt is final.
- A zero-length start and mixed mask and clear writes exercise the status and interrupt path.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  // register byte offsets; channel registers are further offset by channel * stride
  localparam logic [7:0] OFS_MODE    = 8'h00;
  localparam logic [7:0] OFS_START   = 8'h10;
  localparam logic [7:0] OFS_LEN     = 8'h18;
  localparam logic [7:0] OFS_LIVEADR = 8'h20;
  localparam logic [7:0] OFS_LIVELEN = 8'h28;
  localparam logic [7:0] OFS_RUN     = 8'h30;
  localparam logic [7:0] OFS_MASK    = 8'h40;
  localparam logic [7:0] OFS_STAT    = 8'h44;
  localparam logic [7:0] OFS_CLR     = 8'h48;

  // writable mode bits: transmit buffering (12), receive-end (8), wait count (5:4)
  localparam logic [31:0] MODE_KEEP = 32'h0000_1130;
  localparam int WAIT_LSB = 4;

  // per-channel strobes from control to datapath
  typedef struct packed {
    logic load;   // copy start registers into live registers
    logic step;   // one beat accepted this cycle
  } dpStrobe_t;

endpackage

// File: rtl/dmac_datapath.sv
module dmac_datapath
  import dmac_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 32,
  parameter int CW  = 26,
  parameter int DW  = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BW  = DW / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe     [NCH],
  input  logic [AW-1:0]     startAddr  [NCH],
  input  logic [CW-1:0]     startLen   [NCH],
  input  logic [CHW-1:0]    sel,
  input  logic [NCH*DW-1:0] fifoData,
  output logic [AW-1:0]     liveAddr   [NCH],
  output logic [CW-1:0]     liveLen    [NCH],
  output logic [NCH-1:0]    lenZero,
  output logic [AW-1:0]     memAddr,
  output logic [BW-1:0]     memByteEn,
  output logic [DW-1:0]     memWdata
);

  localparam int SZW = $clog2(BW) + 1;

  logic [SZW-1:0] beatBytes [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_comb begin
      if (liveLen[c] >= CW'(BW)) beatBytes[c] = SZW'(BW);
      else                        beatBytes[c] = SZW'(liveLen[c]);
    end

    assign lenZero[c] = (liveLen[c] == '0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        liveAddr[c] <= '0;
        liveLen[c]  <= '0;
      end else if (strobe[c].load) begin
        liveAddr[c] <= startAddr[c];
        liveLen[c]  <= startLen[c];
      end else if (strobe[c].step) begin
        liveAddr[c] <= liveAddr[c] + AW'(beatBytes[c]);
        liveLen[c]  <= liveLen[c] - CW'(beatBytes[c]);
      end
    end
  end

  // beat presented on the memory port comes from the selected channel
  always_comb begin
    memAddr   = liveAddr[sel];
    memWdata  = fifoData[sel*DW +: DW];
    memByteEn = BW'((1 << beatBytes[sel]) - 1);
  end

endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
  import dmac_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int AW        = 32,
  parameter int CW        = 26,
  parameter int RAW       = 8,
  parameter int CH_STRIDE = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           regWr,
  input  logic [RAW-1:0] regAddr,
  input  logic [31:0]    regWdata,
  output logic [31:0]    regRdata,
  input  logic [NCH-1:0] fifoValid,
  output logic [NCH-1:0] fifoPop,
  input  logic           memGnt,
  output logic           memReq,
  output logic [CHW-1:0] sel,
  output logic           irq,
  output dpStrobe_t      strobe    [NCH],
  output logic [AW-1:0]  startAddr [NCH],
  output logic [CW-1:0]  startLen  [NCH],
  input  logic [AW-1:0]  liveAddr  [NCH],
  input  logic [CW-1:0]  liveLen   [NCH],
  input  logic [NCH-1:0] lenZero
);

  function automatic logic [RAW-1:0] chReg(logic [7:0] ofs, int c);
    return RAW'(int'(ofs) + c * CH_STRIDE);
  endfunction

  logic [31:0]    modeWord [NCH];
  logic [1:0]     waitCnt  [NCH];
  logic [NCH-1:0] chEn, req, done, stepV, wrRun;
  logic [NCH-1:0] intMask, intStat, clrBits;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      wrRun[c] = regWr && (regAddr == chReg(OFS_RUN, c));
      done[c]  = chEn[c] && lenZero[c] && !wrRun[c];
      req[c]   = chEn[c] && fifoValid[c] && !lenZero[c] && (waitCnt[c] == 2'd0);
      strobe[c].load = wrRun[c] && regWdata[0];
      strobe[c].step = stepV[c];
    end
  end

  // fixed priority: lowest channel index wins
  always_comb begin
    sel = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (req[c]) sel = CHW'(c);
    end
    memReq = |req;
    stepV  = '0;
    stepV[sel] = memReq && memGnt;
    fifoPop = stepV;
  end

  assign clrBits = (regWr && regAddr == RAW'(OFS_CLR)) ? regWdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chEn    <= '0;
      intMask <= '0;
      intStat <= '0;
      for (int c = 0; c < NCH; c++) begin
        modeWord[c]  <= '0;
        startAddr[c] <= '0;
        startLen[c]  <= '0;
        waitCnt[c]   <= '0;
      end
    end else begin
      if (regWr && regAddr == RAW'(OFS_MASK)) intMask <= regWdata[NCH-1:0];
      intStat <= (intStat & ~clrBits) | done;
      for (int c = 0; c < NCH; c++) begin
        if (regWr && regAddr == chReg(OFS_MODE, c))  modeWord[c]  <= regWdata & MODE_KEEP;
        if (regWr && regAddr == chReg(OFS_START, c)) startAddr[c] <= regWdata[AW-1:0];
        if (regWr && regAddr == chReg(OFS_LEN, c))   startLen[c]  <= regWdata[CW-1:0];
        if (wrRun[c])     chEn[c] <= regWdata[0];
        else if (done[c]) chEn[c] <= 1'b0;
        if (wrRun[c])               waitCnt[c] <= 2'd0;
        else if (stepV[c])          waitCnt[c] <= modeWord[c][WAIT_LSB +: 2];
        else if (waitCnt[c] != '0)  waitCnt[c] <= waitCnt[c] - 2'd1;
      end
    end
  end

  assign irq = |(intStat & intMask);

  always_comb begin
    regRdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (regAddr == chReg(OFS_MODE, c))    regRdata = modeWord[c];
      if (regAddr == chReg(OFS_START, c))   regRdata = 32'(startAddr[c]);
      if (regAddr == chReg(OFS_LEN, c))     regRdata = 32'(startLen[c]);
      if (regAddr == chReg(OFS_LIVEADR, c)) regRdata = 32'(liveAddr[c]);
      if (regAddr == chReg(OFS_LIVELEN, c)) regRdata = 32'(liveLen[c]);
      if (regAddr == chReg(OFS_RUN, c))     regRdata = 32'(chEn[c]);
    end
    if (regAddr == RAW'(OFS_MASK)) regRdata = 32'(intMask);
    if (regAddr == RAW'(OFS_STAT)) regRdata = 32'(intStat);
  end

endmodule

// File: rtl/dual_dma_ctrl.sv
module dual_dma_ctrl
  import dmac_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int AW        = 32,
  parameter int CW        = 26,
  parameter int DW        = 32,
  parameter int RAW       = 8,
  parameter int CH_STRIDE = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BW  = DW / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [RAW-1:0]    regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [NCH-1:0]    fifoValid,
  input  logic [NCH*DW-1:0] fifoData,
  output logic [NCH-1:0]    fifoPop,
  output logic              memReq,
  input  logic              memGnt,
  output logic [CHW-1:0]    memChan,
  output logic [AW-1:0]     memAddr,
  output logic [BW-1:0]     memByteEn,
  output logic [DW-1:0]     memWdata,
  output logic              irq
);

  dpStrobe_t      strobe    [NCH];
  logic [AW-1:0]  startAddr [NCH];
  logic [CW-1:0]  startLen  [NCH];
  logic [AW-1:0]  liveAddr  [NCH];
  logic [CW-1:0]  liveLen   [NCH];
  logic [NCH-1:0] lenZero;

  dmac_ctrl #(.NCH(NCH), .AW(AW), .CW(CW), .RAW(RAW), .CH_STRIDE(CH_STRIDE)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .fifoValid(fifoValid), .fifoPop(fifoPop), .memGnt(memGnt),
    .memReq(memReq), .sel(memChan), .irq(irq), .strobe(strobe), .startAddr(startAddr),
    .startLen(startLen), .liveAddr(liveAddr), .liveLen(liveLen), .lenZero(lenZero)
  );

  dmac_datapath #(.NCH(NCH), .AW(AW), .CW(CW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startAddr(startAddr), .startLen(startLen),
    .sel(memChan), .fifoData(fifoData), .liveAddr(liveAddr), .liveLen(liveLen),
    .lenZero(lenZero), .memAddr(memAddr), .memByteEn(memByteEn), .memWdata(memWdata)
  );

endmodule

// File: rtl/dmac_checker.sv
module dmac_checker #(
  parameter int NCH = 2,
  parameter int RAW = 8,
  parameter int BW  = 4,
  parameter int CH_STRIDE = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rstN,
  input logic           regWr,
  input logic [RAW-1:0] regAddr,
  input logic [31:0]    regWdata,
  input logic           memReq,
  input logic           memGnt,
  input logic [CHW-1:0] memChan,
  input logic [BW-1:0]  memByteEn,
  input logic [NCH-1:0] fifoValid,
  input logic [NCH-1:0] fifoPop,
  input logic           irq,
  input logic [NCH-1:0] chEn,
  input logic [NCH-1:0] intStat
);

  logic haltCh0, runWrCh0;
  assign runWrCh0 = regWr && (regAddr == RAW'(8'h30));
  assign haltCh0  = runWrCh0 && !regWdata[0];

  // R10: a beat is requested only for a channel whose FIFO has data
  assert_req_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> fifoValid[memChan]);

  // R10: an accepted beat pops exactly the owning channel's FIFO
  assert_pop_owner_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memGnt) |-> (fifoPop == (NCH'(1) << memChan)));

  // R10: no pop without an accepted beat
  assert_no_stray_pop_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && memGnt) |-> (fifoPop == '0));

  // R3: byte enables are a contiguous low mask
  assert_byte_mask_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memByteEn == 4'h1 || memByteEn == 4'h3 ||
                memByteEn == 4'h7 || memByteEn == 4'hF));

  // R5: a halt write stops channel 0 in the next cycle
  assert_halt_stops_R5: assert property (@(posedge clk) disable iff (!rstN)
    haltCh0 |=> !chEn[0]);

  // R4: channel 0 dropping its run bit on its own leaves its status bit set
  assert_end_flags_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(chEn[0]) && !$past(runWrCh0)) |-> intStat[0]);

  // R7: the interrupt never rises without a pending status bit
  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (intStat != '0));

endmodule

bind dual_dma_ctrl dmac_checker #(.NCH(NCH), .RAW(RAW), .BW(BW), .CH_STRIDE(CH_STRIDE)) u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
  .memReq(memReq), .memGnt(memGnt), .memChan(memChan), .memByteEn(memByteEn),
  .fifoValid(fifoValid), .fifoPop(fifoPop), .irq(irq),
  .chEn(u_ctrl.chEn), .intStat(u_ctrl.intStat)
);

// File: tb/sim_dual_dma_ctrl.sv
module sim_dual_dma_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [1:0]  fifoValid = '0;
  logic [63:0] fifoData = '0;
  logic [1:0]  fifoPop;
  logic        memReq;
  logic        memGnt = 1'b0;
  logic [0:0]  memChan;
  logic [31:0] memAddr;
  logic [3:0]  memByteEn;
  logic [31:0] memWdata;
  logic        irq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit randMode = 0;
  bit strictGap = 0;
  bit prioMode = 0;
  bit finished = 0;

  logic [31:0] expAddr  [2];
  int          expRem   [2];
  int          bytesSeen[2];
  int          waitOf   [2];
  int          lastBeat [2];
  int          firstCh;

  dual_dma_ctrl u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .fifoValid(fifoValid), .fifoData(fifoData), .fifoPop(fifoPop),
    .memReq(memReq), .memGnt(memGnt), .memChan(memChan), .memAddr(memAddr),
    .memByteEn(memByteEn), .memWdata(memWdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int beatSize(int rem);
    return (rem >= 4) ? 4 : rem;
  endfunction

  function automatic logic [7:0] regOf(logic [7:0] ofs, int ch);
    return ofs + 8'(ch * 4);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWr = 1'b0;
  endtask

  task automatic regRead(logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    regAddr = a;
    #2 d = regRdata;
  endtask

  task automatic startChan(int ch, logic [31:0] base, int len, int w);
    regWrite(regOf(8'h00, ch), 32'(w) << 4);
    regWrite(regOf(8'h10, ch), base);
    regWrite(regOf(8'h18, ch), 32'(len));
    expAddr[ch] = base; expRem[ch] = len; bytesSeen[ch] = 0;
    waitOf[ch] = w; lastBeat[ch] = -1;
    regWrite(regOf(8'h30, ch), 32'h1);
  endtask

  task automatic waitIdle(int ch);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      regRead(regOf(8'h30, ch), v);
      if (v == 0) break;
    end
  endtask

  task automatic checkEnd(string tag, int ch, logic [31:0] base, int len);
    logic [31:0] v;
    regRead(regOf(8'h30, ch), v);   check({tag, " run cleared"}, v, 0);
    regRead(regOf(8'h20, ch), v);   check({tag, " live address"}, v, base + 32'(len));
    regRead(regOf(8'h28, ch), v);   check({tag, " live count"}, v, 0);
    check({tag, " bytes moved"}, 32'(bytesSeen[ch]), 32'(len));
    regRead(8'h44, v);              check({tag, " status bit"}, 32'(v[ch]), 1);
  endtask

  // input driver: random throttling a little after each rising edge
  always @(posedge clk) begin
    #1;
    fifoData = {$urandom, $urandom};
    if (randMode) begin
      fifoValid = 2'($urandom);
      memGnt = 1'($urandom);
    end
  end

  // beat monitor samples at the falling edge; the beat is taken at the next rising edge
  always @(negedge clk) begin
    if (rstN && memReq && memGnt) begin
      int ch;
      int sz;
      ch = int'(memChan);
      sz = beatSize(expRem[ch]);
      if (firstCh < 0) firstCh = ch;
      check("R10 beat needs valid", 32'(fifoValid[ch]), 1);
      check("R10 pop owner", 32'(fifoPop), 32'(1 << ch));
      check("R10 data", memWdata, fifoData[ch*32 +: 32]);
      check("R3 beat address", memAddr, expAddr[ch]);
      check("R3 byte enables", 32'(memByteEn), 32'((1 << sz) - 1));
      if (expRem[ch] == 0) check("R5 no beat when idle", 1, 0);
      if (prioMode && ch == 1) check("R9 ch0 first", 32'(expRem[0]), 0);
      if (lastBeat[ch] >= 0) begin
        if (strictGap) check("R8 exact gap", 32'(cyc - lastBeat[ch]), 32'(waitOf[ch] + 1));
        else check("R8 min gap", 32'(cyc - lastBeat[ch] >= waitOf[ch] + 1), 1);
      end
      lastBeat[ch] = cyc;
      expAddr[ch] += 32'(sz);
      expRem[ch] -= sz;
      bytesSeen[ch] += sz;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    for (int c = 0; c < 2; c++) begin
      expRem[c] = 0; bytesSeen[c] = 0; waitOf[c] = 0; lastBeat[c] = -1; expAddr[c] = 0;
    end
    firstCh = -1;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R12: reset state
    regRead(8'h00, v); check("R12 mode0", v, 0);
    regRead(8'h34, v); check("R12 run1", v, 0);
    regRead(8'h44, v); check("R12 status", v, 0);
    check("R12 irq", 32'(irq), 0);
    check("R12 memReq", 32'(memReq), 0);

    // R1: register map and mode masking
    regWrite(8'h00, 32'hFFFF_FFFF);
    regRead(8'h00, v); check("R1 mode0 kept bits", v, 32'h0000_1130);
    regWrite(8'h04, 32'h0000_0010);
    regRead(8'h04, v); check("R1 mode1 wait field", v, 32'h10);
    regRead(8'h00, v); check("R1 mode0 untouched", v, 32'h0000_1130);
    regWrite(8'h14, 32'hCAFE_0000);
    regRead(8'h14, v); check("R1 start1", v, 32'hCAFE_0000);
    regWrite(8'h1C, 32'hFFFF_FFFF);
    regRead(8'h1C, v); check("R1 len 26 bits", v, 32'h03FF_FFFF);
    regWrite(8'h40, 32'hFF);
    regRead(8'h40, v); check("R1 mask width", v, 32'h3);
    regWrite(8'h40, 32'h0);

    // R11: zero-length start
    startChan(0, 32'h0000_0200, 0, 0);
    repeat (3) @(posedge clk);
    regRead(8'h30, v); check("R11 run cleared", v, 0);
    regRead(8'h44, v); check("R11 status set", 32'(v[0]), 1);
    check("R11 no beats", 32'(bytesSeen[0]), 0);
    regWrite(8'h48, 32'h3);
    regRead(8'h44, v); check("R6 clear", v, 0);

    // R8: exact wait gap with inputs held ready
    fifoValid = 2'b01; memGnt = 1'b1; strictGap = 1;
    startChan(0, 32'h0000_1000, 18, 2);
    waitIdle(0);
    checkEnd("R8/R4 ch0", 0, 32'h0000_1000, 18);
    strictGap = 0; fifoValid = 2'b00;
    regWrite(8'h48, 32'h1);

    // R9: both channels ready together, channel 0 must win
    startChan(1, 32'h0000_3000, 8, 0);
    startChan(0, 32'h0000_2000, 12, 0);
    prioMode = 1; firstCh = -1;
    @(posedge clk); #1 fifoValid = 2'b11;
    waitIdle(1);
    check("R9 first beat channel", 32'(firstCh), 0);
    checkEnd("R9/R4 ch0", 0, 32'h0000_2000, 12);
    checkEnd("R9/R4 ch1", 1, 32'h0000_3000, 8);
    prioMode = 0; fifoValid = 2'b00;

    // R7 and R6: masking and write-one-to-clear
    regWrite(8'h40, 32'h2);
    #1 check("R7 irq masked on", 32'(irq), 1);
    regWrite(8'h44, 32'h0);
    regRead(8'h44, v); check("R6 status write ignored", v, 32'h3);
    regWrite(8'h48, 32'h2);
    regRead(8'h44, v); check("R6 clear one bit", v, 32'h1);
    #1 check("R7 irq masked off", 32'(irq), 0);
    regWrite(8'h48, 32'h1);

    // R2 and R5: start with FIFO empty, then halt
    startChan(1, 32'h0000_4004, 20, 1);
    regRead(8'h34, v); check("R2 run reads 1", v, 1);
    regRead(8'h24, v); check("R2 live address", v, 32'h0000_4004);
    regRead(8'h2C, v); check("R2 live count", v, 20);
    regWrite(8'h34, 32'h0);
    expRem[1] = 0;
    regRead(8'h34, v); check("R5 halted", v, 0);
    fifoValid = 2'b11; memGnt = 1'b1;
    repeat (6) @(posedge clk);
    regRead(8'h2C, v); check("R5 count held", v, 20);
    regRead(8'h44, v); check("R5 no status", v, 0);
    check("R5 no beats", 32'(bytesSeen[1]), 0);
    fifoValid = 2'b00; memGnt = 1'b0;

    // random transfers on both channels
    randMode = 1;
    for (int it = 0; it < 30; it++) begin
      logic [31:0] b0, b1, m;
      int l0, l1;
      b0 = $urandom; b1 = $urandom;
      l0 = int'($urandom_range(0, 50)); l1 = int'($urandom_range(0, 50));
      m = 32'($urandom_range(0, 3));
      regWrite(8'h40, m);
      startChan(1, b1, l1, int'($urandom_range(0, 3)));
      startChan(0, b0, l0, int'($urandom_range(0, 3)));
      waitIdle(0);
      waitIdle(1);
      checkEnd("R3/R4 rand ch0", 0, b0, l0);
      checkEnd("R3/R4 rand ch1", 1, b1, l1);
      #1 check("R7 rand irq", 32'(irq), 32'(m[1:0] != 0));
      regWrite(8'h48, 32'h3);
      regRead(8'h44, v); check("R6 rand clear", v, 0);
    end
    randMode = 0;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule